// File: doc/BRIEF.md
# Triggered Signal Capture Buffer

This block is an on-chip logic-analyzer core. While armed it writes the 16-bit probe bus into a 1024-entry circular memory on every clock. It also compares the probe against a masked trigger value. Once an edge-qualified match arrives, it records 512 more samples, the trigger sample among them. It then freezes the memory and sends the whole window, oldest sample first, as a byte stream to a UART transmitter through a valid/ready handshake.

The window is centred on the event. Half the samples come from before the trigger and half from after it, and the trigger sample sits at a fixed index, so the host can find it. When the last byte of a frame is accepted, the core re-arms by itself. It then takes a new capture each time the trigger condition appears again.

Top module: `scope_capture`

## Requirements
- R1: While rst_ni is low, tx_valid_o is low and the core is held armed with an empty fill count. After release, capture starts over, and no earlier samples count toward the pre-trigger history.
- R2: In every cycle of the armed and post-trigger phases, the probe value is stored. The dumped samples are consecutive probe values in the order they were sampled, oldest first.
- R3: The trigger condition is (probe_i & trig_mask_i) == (trig_value_i & trig_mask_i). Probe bits whose mask bit is 0 have no effect on it.
- R4: A trigger fires only on a matching cycle whose preceding cycle did not match. A match held over several cycles produces at most one trigger, at its first cycle.
- R5: A trigger is accepted only once 512 samples have been written since arming, and earlier matches are ignored. A match on the sample with index 512 after arming is accepted.
- R6: A frame carries 1024 samples. The first 512 precede the trigger, the trigger sample is sample index 512, and 511 samples follow it.
- R7: Frame layout: byte 0 is 0xA5, and bytes 1 and 2 hold the sample count 0x0400, most significant byte first. Each sample follows as two bytes, most significant byte first, so a frame is 2051 bytes.
- R8: A byte is consumed only in a cycle where tx_valid_o and tx_ready_i are both high. While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_byte_o hold.
- R9: While a frame is being sent, no sample is written and trigger matches are ignored.
- R10: In the cycle after the last frame byte is accepted, the core is armed again with a zero fill count. It then produces a new frame on the next qualified trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling and transmit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| probe_i | input | 16 | Probed signal bus |
| trig_value_i | input | 16 | Trigger comparison value |
| trig_mask_i | input | 16 | Trigger compare mask, 1 = bit compared |
| tx_byte_o | output | 8 | Frame byte toward the UART transmitter |
| tx_valid_o | output | 1 | tx_byte_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts the byte this cycle |

## Verification
The assertions check several rules on every cycle. They check that the byte stays stable under back-pressure and that every frame opens with the sync byte. They check that the write pointer advances once per write, that it freezes during transmission, and that it stands exactly half a buffer past the trigger address when the dump begins. They also check that the fill count is saturated during post-trigger sampling and is cleared at re-arm. Only the bench's scenarios can show which probe cycle actually fired and that the dumped window matches the probe history in content. This covers the masked compare, edge qualification where a match spans the fill boundary, and the exact 512-sample threshold. The bench also shows that matches during a dump are ignored and that each automatic re-arm produces a correct frame.

// File: rtl/scope_pkg.sv
package scope_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_POST  = 2'd1,
    ST_DUMP  = 2'd2
  } scope_state_e;

  localparam logic [7:0] SYNC_BYTE = 8'hA5;
endpackage

// File: rtl/scope_trig.sv
module scope_trig #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] probe_i,
  input  logic [SAMPLE_W-1:0] value_i,
  input  logic [SAMPLE_W-1:0] mask_i,
  input  logic                en_i,
  output logic                fire_o
);
  logic hit;
  logic hit_prev_q;

  assign hit = ((probe_i ^ value_i) & mask_i) == '0;

  // history tracks the probe in every state so edges stay correct after a dump
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_prev_q <= 1'b0;
    else         hit_prev_q <= hit;
  end

  assign fire_o = en_i & hit & ~hit_prev_q;
endmodule

// File: rtl/scope_buf.sv
module scope_buf #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [ADDR_W-1:0]   wr_ptr_o,
  output logic [SAMPLE_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]   wr_ptr_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_ptr_q <= '0;
    else if (we_i) wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  assign wr_ptr_o  = wr_ptr_q;
  assign rd_data_o = mem[rd_addr_i];

  assert_ptr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (wr_ptr_q == ADDR_W'($past(wr_ptr_q) + 1'b1)));
endmodule

// File: rtl/scope_dump.sv
module scope_dump #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ready_i,
  input  logic [ADDR_W-1:0]   start_addr_i,
  input  logic [SAMPLE_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0]   rd_addr_o,
  output logic [7:0]          data_o,
  output logic                valid_o,
  output logic                done_o
);
  import scope_pkg::*;

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int BPS       = SAMPLE_W / 8;
  localparam int HDR_LEN   = 3;
  localparam int FRAME_LEN = HDR_LEN + BPS * DEPTH;
  localparam int BW        = $clog2(FRAME_LEN);
  localparam logic [15:0] COUNT_FIELD = 16'(DEPTH);
  localparam logic [BW-1:0] LAST_IDX  = BW'(FRAME_LEN - 1);

  logic [BW-1:0]       bcnt_q;
  logic [BW-1:0]       body_idx;
  logic [BW-1:0]       samp_idx;
  logic [BW-1:0]       part_idx;
  logic [SAMPLE_W-1:0] shifted;
  logic                last;

  assign last     = bcnt_q == LAST_IDX;
  assign body_idx = bcnt_q - BW'(HDR_LEN);
  assign samp_idx = body_idx / BW'(BPS);
  assign part_idx = body_idx % BW'(BPS);
  assign rd_addr_o = start_addr_i + ADDR_W'(samp_idx);
  assign shifted  = rd_data_i >> (8 * (BPS - 1 - int'(part_idx)));

  always_comb begin
    unique case (bcnt_q)
      BW'(0):  data_o = SYNC_BYTE;
      BW'(1):  data_o = COUNT_FIELD[15:8];
      BW'(2):  data_o = COUNT_FIELD[7:0];
      default: data_o = shifted[7:0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               bcnt_q <= '0;
    else if (en_i && ready_i)  bcnt_q <= last ? '0 : bcnt_q + 1'b1;
  end

  assign valid_o = en_i;
  assign done_o  = en_i & ready_i & last;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  assert_sync_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (data_o == SYNC_BYTE));
endmodule

// File: rtl/scope_capture.sv
module scope_capture #(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] probe_i,
  input  logic [SAMPLE_W-1:0] trig_value_i,
  input  logic [SAMPLE_W-1:0] trig_mask_i,
  output logic [7:0]          tx_byte_o,
  output logic                tx_valid_o,
  input  logic                tx_ready_i
);
  import scope_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [ADDR_W-1:0] HALF_A      = ADDR_W'(HALF);
  localparam logic [ADDR_W-1:0] POST_RELOAD = ADDR_W'(HALF - 2);

  scope_state_e      state_q;
  logic [ADDR_W-1:0] fill_q;
  logic [ADDR_W-1:0] post_q;
  logic [ADDR_W-1:0] trig_addr_q;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] start_addr;
  logic [SAMPLE_W-1:0] rd_data;
  logic fill_full;
  logic fire;
  logic we;
  logic dump_en;
  logic dump_done;

  assign fill_full  = fill_q == HALF_A;
  assign we         = state_q != ST_DUMP;
  assign dump_en    = state_q == ST_DUMP;
  assign start_addr = trig_addr_q - HALF_A;

  scope_trig #(.SAMPLE_W(SAMPLE_W)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .probe_i (probe_i),
    .value_i (trig_value_i),
    .mask_i  (trig_mask_i),
    .en_i    ((state_q == ST_ARMED) && fill_full),
    .fire_o  (fire)
  );

  scope_buf #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wdata_i   (probe_i),
    .rd_addr_i (rd_addr),
    .wr_ptr_o  (wr_ptr),
    .rd_data_o (rd_data)
  );

  scope_dump #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) u_dump (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (dump_en),
    .ready_i      (tx_ready_i),
    .start_addr_i (start_addr),
    .rd_data_i    (rd_data),
    .rd_addr_o    (rd_addr),
    .data_o       (tx_byte_o),
    .valid_o      (tx_valid_o),
    .done_o       (dump_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ARMED;
      fill_q      <= '0;
      post_q      <= '0;
      trig_addr_q <= '0;
    end else begin
      unique case (state_q)
        ST_ARMED: begin
          if (!fill_full) fill_q <= fill_q + 1'b1;
          if (fire) begin
            trig_addr_q <= wr_ptr;
            post_q      <= POST_RELOAD;
            state_q     <= ST_POST;
          end
        end
        ST_POST: begin
          // trigger cycle wrote one sample; HALF-1 more follow
          if (post_q == '0) state_q <= ST_DUMP;
          else              post_q  <= post_q - 1'b1;
        end
        ST_DUMP: begin
          if (dump_done) begin
            state_q <= ST_ARMED;
            fill_q  <= '0;
          end
        end
        default: state_q <= ST_ARMED;
      endcase
    end
  end

  assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST) |-> (fill_q == HALF_A));

  assert_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POST && post_q == '0) |=>
      (state_q == ST_DUMP && wr_ptr == ADDR_W'(trig_addr_q + HALF_A)));

  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DUMP) |=> $stable(wr_ptr));

  assert_rearm_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_done |=> (state_q == ST_ARMED && fill_q == '0));
endmodule

// File: tb/tb_scope_capture.sv
`timescale 1ns/1ps
module tb_scope_capture;
  localparam int AW        = 10;
  localparam int DEPTH     = 1 << AW;
  localparam int HALF      = DEPTH / 2;
  localparam int FRAME_LEN = 3 + 2 * DEPTH;
  localparam int NVEC      = 4;
  // {mask, value, ready stall period (0 = always ready)}
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hFFFF, 16'h0300, 16'd0},
    {16'h00FF, 16'h0010, 16'd3},
    {16'h0F0F, 16'h0305, 16'd2},
    {16'h0300, 16'h0100, 16'd5}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] probe = '0;
  logic [15:0] tval = '0;
  logic [15:0] tmask = '0;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int period = 0;
  int nbytes = 0;
  logic [15:0] cnt = '0;
  logic        arm_next = 1'b0;
  logic [15:0] arm_val = '0;
  logic        prev_valid = 1'b0;
  logic        prev_ready = 1'b0;
  logic [7:0]  prev_data = '0;
  logic [7:0]  fr [FRAME_LEN];

  always #2.5 clk = ~clk;

  scope_capture dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .probe_i      (probe),
    .trig_value_i (tval),
    .trig_mask_i  (tmask),
    .tx_byte_o    (tx_byte),
    .tx_valid_o   (tx_valid),
    .tx_ready_i   (tx_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (prev_valid && !prev_ready)
      chk(tx_valid && tx_byte == prev_data, "R8 byte held while stalled",
          {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, prev_data});
    cnt = cnt + 16'd1;
    probe = cnt;
    if (arm_next) begin
      arm_val  = cnt;
      arm_next = 1'b0;
    end
    tx_ready = (period == 0) ? 1'b1 : ((cyc % period) != 0);
    if (rst_ni && tx_valid && tx_ready && nbytes < FRAME_LEN) begin
      fr[nbytes] = tx_byte;
      nbytes++;
      if (nbytes == FRAME_LEN) arm_next = 1'b1;
    end
    prev_valid = tx_valid;
    prev_ready = tx_ready;
    prev_data  = tx_byte;
  endtask

  function automatic logic [15:0] model_trig(input logic [15:0] a, input logic [15:0] m, input logic [15:0] v);
    logic [15:0] t;
    t = a + 16'(HALF);
    for (int k = 0; k < 70000; k++) begin
      if ((((t ^ v) & m) == 16'd0) && ((((t - 16'd1) ^ v) & m) != 16'd0)) return t;
      t = t + 16'd1;
    end
    return t;
  endfunction

  task automatic do_reset(input logic [15:0] base);
    @(negedge clk);
    #1 rst_ni = 1'b0;
    prev_valid = 1'b0;
    #1 chk(tx_valid == 1'b0, "R1 valid low in reset", {31'd0, tx_valid}, 32'd0);
    repeat (3) tick();
    prev_valid = 1'b0;
    @(posedge clk);
    #1 rst_ni = 1'b1;
    cnt = base - 16'd1;
    arm_next = 1'b1;
    nbytes = 0;
  endtask

  task automatic run_capture(input logic [15:0] m, input logic [15:0] v, input int per,
                             input int stop_at, output logic [15:0] trig_exp);
    tmask = m;
    tval = v;
    period = per;
    nbytes = 0;
    tick();
    trig_exp = model_trig(arm_val, m, v);
    while (nbytes < stop_at) tick();
  endtask

  function automatic logic [15:0] sample_at(input int i);
    return {fr[3 + 2 * i], fr[4 + 2 * i]};
  endfunction

  task automatic check_frame(input logic [15:0] trig_exp, input string tag);
    int bad_i;
    logic [15:0] s0;
    chk(fr[0] == 8'hA5, "R7 sync byte", {24'd0, fr[0]}, 32'hA5);
    chk({fr[1], fr[2]} == 16'h0400, "R7 count field", {16'd0, fr[1], fr[2]}, 32'h0400);
    chk(sample_at(HALF) == trig_exp, {"R6 trigger sample ", tag},
        {16'd0, sample_at(HALF)}, {16'd0, trig_exp});
    bad_i = -1;
    for (int i = 0; i < DEPTH; i++)
      if (bad_i < 0 && sample_at(i) != 16'(trig_exp - 16'(HALF) + 16'(i))) bad_i = i;
    chk(bad_i < 0, "R2 R9 consecutive history", bad_i < 0 ? 32'd0 : {16'd0, sample_at(bad_i)},
        bad_i < 0 ? 32'd0 : {16'd0, 16'(trig_exp - 16'(HALF) + 16'(bad_i))});
    s0 = sample_at(0);
    chk(16'(s0 - arm_val) < 16'h8000, "R10 window starts after arming", {16'd0, s0}, {16'd0, arm_val});
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] te;
    do_reset(16'h0000);
    tick();
    chk(tx_valid == 1'b0, "R1 idle after reset", {31'd0, tx_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      run_capture(VEC[i][47:32], VEC[i][31:16], int'(VEC[i][15:0]), FRAME_LEN, te);
      chk(nbytes == FRAME_LEN, "R10 frame after re-arm", nbytes, FRAME_LEN);
      check_frame(te, "R3 masked match");
    end

    // matches at 0x080 and 0x180 precede the fill threshold
    do_reset(16'h0000);
    run_capture(16'h00FF, 16'h0080, 0, FRAME_LEN, te);
    check_frame(te, "R5");
    chk(sample_at(HALF) == 16'h0280, "R5 early matches ignored", {16'd0, sample_at(HALF)}, 32'h0280);

    // match run already active when fill completes at 0x0380
    do_reset(16'h0180);
    run_capture(16'h0300, 16'h0300, 0, FRAME_LEN, te);
    check_frame(te, "R4");
    chk(sample_at(HALF) == 16'h0700, "R4 held match not retriggered", {16'd0, sample_at(HALF)}, 32'h0700);

    // abort a dump with reset, then trigger exactly at the threshold
    run_capture(16'h00FF, 16'h0040, 0, 100, te);
    do_reset(16'h1000);
    tick();
    chk(tx_valid == 1'b0, "R1 dump dropped by reset", {31'd0, tx_valid}, 32'd0);
    nbytes = 0;
    tmask = 16'hFFFF;
    tval = 16'h1200;
    while (nbytes < FRAME_LEN) tick();
    check_frame(16'h1200, "R5 threshold");
    chk(sample_at(0) == 16'h1000, "R5 window starts at arming", {16'd0, sample_at(0)}, 32'h1000);

    repeat (4) tick();
    summary();
    $finish;
  end
endmodule